// File: doc/BRIEF.md
# Stochastic Bit-Stream Conversion Sequencer

This block runs one conversion of a probabilistic converter whose analog front end is a switching element with a random, input-dependent outcome. A conversion is a series of identical trials. In each trial the block requests a reset pulse, waits for a settling gap, requests a short perturb pulse, waits for a second gap, and then strobes the sense amplifier and takes its one-bit answer. A value of 1 means the element switched. The block counts the ones over a power-of-two number of trials. It then publishes the fraction of ones as a fixed-width code.

Software or a higher-level controller sets the trial count and the three phase lengths, then raises `start`. `busy` stays high while trials run. A one-cycle `done` marks the cycle in which `code` takes its new value. The pulse lengths are given in clock cycles. At a 200 MHz clock, a perturb length of 1 gives a 5 ns pulse. The default build uses an 8-bit code and supports from 16 up to 4096 trials per conversion. Typical settings are 64, 128, 512, 2048 (the usual choice) or 4096.

Top module: `sbs_conv_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `rst_pulse`, `prt_pulse` and `read_stb` are low and `code` is 0.
- R2: `start` is accepted only while `busy` is low. While a conversion is running, `start` has no effect on its timing, trial count or result.
- R3: Each trial requests its outputs in a fixed order: `rst_pulse`, then a gap, then `prt_pulse`, then a gap, then `read_stb`. The next trial's `rst_pulse` follows `read_stb` directly. No two of `rst_pulse`, `prt_pulse`, `read_stb` and `done` are ever high in the same cycle.
- R4: `rst_pulse` stays high for `rst_len` cycles, `prt_pulse` for `prt_len` cycles, and each gap lasts `gap_len` cycles. A length of 0 acts as 1. `read_stb` lasts one cycle. The lengths are captured when `start` is accepted, and later changes to these inputs do not affect the running conversion.
- R5: A conversion runs exactly 2^k trials, where k is `trial_log2` clamped to the range 4..12 and captured when `start` is accepted. For example, 6 gives 64 trials, 11 gives 2048 and 12 gives 4096.
- R6: `sense_bit` is taken only at the clock edge that ends a `read_stb` cycle. Its value in every other cycle is ignored.
- R7: With n ones counted in 2^k trials, `code` = floor(n·2^8 / 2^k); for k ≥ 8 this is the top 8 bits of the ones count. If every trial gave a one, the result saturates at 255.
- R8: `done` is high for one cycle, exactly N·T cycles after the edge that accepts `start`. Here N is the trial count and T = rst_len + prt_len + 2·gap_len + 1, with lengths of 0 counted as 1. `code` holds the new value in that same cycle, and `busy` is low in the next cycle.
- R9: `code` changes only in a cycle where `done` is high. Between done pulses it holds its value, including while the next conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion (accepted when idle) |
| trial_log2 | input | 4 | Base-2 logarithm of trials per conversion, clamped to 4..12 |
| rst_len | input | 8 | Reset pulse length in cycles (0 acts as 1) |
| prt_len | input | 8 | Perturb pulse length in cycles (0 acts as 1) |
| gap_len | input | 8 | Settling gap length in cycles (0 acts as 1) |
| sense_bit | input | 1 | Sense amplifier result, 1 = element switched |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion marker |
| rst_pulse | output | 1 | Reset pulse request |
| prt_pulse | output | 1 | Perturb pulse request |
| read_stb | output | 1 | Sense strobe; `sense_bit` is taken at the edge ending it |
| code | output | 8 | Output code, held between conversions |

## Verification
All strobes are decoded from one registered phase. Each strobe is therefore due in the cycle after the edge that enters its phase. The bench looks at them on the falling clock edge, one cycle per observation, and checks run lengths and the gaps between runs against the captured settings. The bench drives a fresh random sense value on every falling edge, and it counts a value only when `read_stb` is high in that cycle, because that is the bit the next rising edge takes. The done cycle is due at observation number N·T+1, counted from the first falling edge after the accepting edge. The bench compares the code in that observation, checks `busy` one observation later, and keeps comparing the held code on every observation of the following conversion.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RST   = 3'd1,
        PH_GAP_A = 3'd2,
        PH_PRT   = 3'd3,
        PH_GAP_B = 3'd4,
        PH_READ  = 3'd5,
        PH_FIN   = 3'd6
    } phase_e;

    function automatic logic is_timed(input phase_e p);
        return (p == PH_RST) || (p == PH_GAP_A) || (p == PH_PRT) || (p == PH_GAP_B);
    endfunction

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/sbs_phase_timer.sv
module sbs_phase_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             expired
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sbs_trial_ctrl.sv
module sbs_trial_ctrl
    import sbs_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int LOG_W    = 4,
    parameter int CNT_W    = 13,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LOG_W-1:0] trial_log2,
    input  logic [LEN_W-1:0] rst_len,
    input  logic [LEN_W-1:0] prt_len,
    input  logic [LEN_W-1:0] gap_len,
    input  logic             timer_expired,
    output phase_e           phase,
    output logic             timer_load,
    output logic [LEN_W-1:0] timer_val,
    output logic [LOG_W-1:0] cfg_log2,
    output logic             last_trial,
    output logic             accept
);
    typedef struct packed {
        logic [LEN_W-1:0] rst_len;
        logic [LEN_W-1:0] prt_len;
        logic [LEN_W-1:0] gap_len;
        logic [LOG_W-1:0] log2;
    } cfg_t;

    cfg_t             cfg;
    phase_e           nxt;
    logic [CNT_W-1:0] trial_cnt;
    logic [CNT_W-1:0] trial_lim;

    function automatic logic [LEN_W-1:0] len_m1(input logic [LEN_W-1:0] x);
        return (x == '0) ? '0 : x - LEN_W'(1);
    endfunction

    function automatic logic [LOG_W-1:0] clamp_k(input logic [LOG_W-1:0] v);
        return LOG_W'(clamp_int(int'(v), MIN_LOG2, MAX_LOG2));
    endfunction

    assign accept     = (phase == PH_IDLE) && start;
    assign trial_lim  = (CNT_W'(1) << cfg.log2) - CNT_W'(1);
    assign last_trial = (trial_cnt == trial_lim);
    assign cfg_log2   = cfg.log2;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:  nxt = start ? PH_RST : PH_IDLE;
            PH_RST:   nxt = timer_expired ? PH_GAP_A : PH_RST;
            PH_GAP_A: nxt = timer_expired ? PH_PRT : PH_GAP_A;
            PH_PRT:   nxt = timer_expired ? PH_GAP_B : PH_PRT;
            PH_GAP_B: nxt = timer_expired ? PH_READ : PH_GAP_B;
            PH_READ:  nxt = last_trial ? PH_FIN : PH_RST;
            PH_FIN:   nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        timer_load = (nxt != phase) && is_timed(nxt);
        unique case (nxt)
            PH_RST:   timer_val = (phase == PH_IDLE) ? len_m1(rst_len) : len_m1(cfg.rst_len);
            PH_PRT:   timer_val = len_m1(cfg.prt_len);
            PH_GAP_A,
            PH_GAP_B: timer_val = len_m1(cfg.gap_len);
            default:  timer_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg       <= '0;
            trial_cnt <= '0;
        end else begin
            phase <= nxt;
            if (accept) begin
                cfg.rst_len <= rst_len;
                cfg.prt_len <= prt_len;
                cfg.gap_len <= gap_len;
                cfg.log2    <= clamp_k(trial_log2);
                trial_cnt   <= '0;
            end else if (phase == PH_READ) begin
                trial_cnt <= trial_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sbs_ones_tally.sv
module sbs_ones_tally #(
    parameter int CNT_W  = 13,
    parameter int CODE_W = 8,
    parameter int LOG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              last,
    input  logic              sense_bit,
    input  logic [LOG_W-1:0]  log2,
    output logic [CODE_W-1:0] code
);
    localparam int WIDE_W = CNT_W + CODE_W;

    logic [CNT_W-1:0]  ones;
    logic [CNT_W-1:0]  ones_nxt;
    logic [WIDE_W-1:0] wide;
    logic [CODE_W-1:0] code_nxt;

    assign ones_nxt = ones + CNT_W'(sense_bit);
    assign wide     = {ones_nxt, {CODE_W{1'b0}}} >> log2;
    assign code_nxt = (|wide[WIDE_W-1:CODE_W]) ? '1 : wide[CODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ones <= '0;
            code <= '0;
        end else if (clear) begin
            ones <= '0;
        end else if (sample) begin
            ones <= ones_nxt;
            if (last) begin
                code <= code_nxt;
            end
        end
    end
endmodule

// File: rtl/sbs_conv_seq.sv
module sbs_conv_seq
    import sbs_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 12,
    parameter int LEN_W    = 8,
    localparam int CNT_W   = MAX_LOG2 + 1,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LOG_W-1:0]  trial_log2,
    input  logic [LEN_W-1:0]  rst_len,
    input  logic [LEN_W-1:0]  prt_len,
    input  logic [LEN_W-1:0]  gap_len,
    input  logic              sense_bit,
    output logic              busy,
    output logic              done,
    output logic              rst_pulse,
    output logic              prt_pulse,
    output logic              read_stb,
    output logic [CODE_W-1:0] code
);
    phase_e           phase;
    logic             timer_load;
    logic [LEN_W-1:0] timer_val;
    logic             timer_expired;
    logic [LOG_W-1:0] cfg_log2;
    logic             last_trial;
    logic             accept;

    sbs_trial_ctrl #(
        .LEN_W(LEN_W), .LOG_W(LOG_W), .CNT_W(CNT_W),
        .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
    ) i_ctrl (
        .clk(clk), .rst(rst), .start(start), .trial_log2(trial_log2),
        .rst_len(rst_len), .prt_len(prt_len), .gap_len(gap_len),
        .timer_expired(timer_expired), .phase(phase),
        .timer_load(timer_load), .timer_val(timer_val),
        .cfg_log2(cfg_log2), .last_trial(last_trial), .accept(accept)
    );

    sbs_phase_timer #(.LEN_W(LEN_W)) i_timer (
        .clk(clk), .rst(rst), .load(timer_load),
        .load_val(timer_val), .expired(timer_expired)
    );

    sbs_ones_tally #(.CNT_W(CNT_W), .CODE_W(CODE_W), .LOG_W(LOG_W)) i_tally (
        .clk(clk), .rst(rst), .clear(accept),
        .sample(phase == PH_READ), .last(last_trial),
        .sense_bit(sense_bit), .log2(cfg_log2), .code(code)
    );

    assign busy      = (phase != PH_IDLE);
    assign done      = (phase == PH_FIN);
    assign rst_pulse = (phase == PH_RST);
    assign prt_pulse = (phase == PH_PRT);
    assign read_stb  = (phase == PH_READ);
endmodule

// File: rtl/sbs_conv_seq_chk.sv
module sbs_conv_seq_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              rst_pulse,
    input logic              prt_pulse,
    input logic              read_stb,
    input logic [CODE_W-1:0] code
);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_pulse, prt_pulse, read_stb, done}));

    assert_gap_before_perturb_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(prt_pulse) |-> !$past(rst_pulse));

    assert_gap_before_read_R3: assert property (@(posedge clk) disable iff (rst)
        read_stb |-> (!$past(prt_pulse) && !$past(read_stb)));

    assert_read_single_R4: assert property (@(posedge clk) disable iff (rst)
        read_stb |=> (rst_pulse || done));

    assert_no_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_code_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(code));
endmodule

bind sbs_conv_seq sbs_conv_seq_chk #(.CODE_W(CODE_W)) i_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .rst_pulse(rst_pulse), .prt_pulse(prt_pulse),
    .read_stb(read_stb), .code(code)
);

// File: tb/test_sbs_conv_seq.sv
module test_sbs_conv_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] trial_log2 = 4'd4;
    logic [7:0] rst_len = 8'd1;
    logic [7:0] prt_len = 8'd1;
    logic [7:0] gap_len = 8'd1;
    logic       sense_bit = 1'b0;
    logic       busy, done, rst_pulse, prt_pulse, read_stb;
    logic [7:0] code;

    int checks = 0;
    int errs   = 0;

    always #2.5 clk = ~clk;

    sbs_conv_seq i_sbs_conv_seq (
        .clk(clk), .rst(rst), .start(start), .trial_log2(trial_log2),
        .rst_len(rst_len), .prt_len(prt_len), .gap_len(gap_len),
        .sense_bit(sense_bit), .busy(busy), .done(done),
        .rst_pulse(rst_pulse), .prt_pulse(prt_pulse),
        .read_stb(read_stb), .code(code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_k(input int v);
        return (v < 4) ? 4 : ((v > 12) ? 12 : v);
    endfunction

    function automatic int len1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic int exp_code(input longint ones, input int k);
        longint w = (ones << 8) >> k;
        return (w > 255) ? 255 : int'(w);
    endfunction

    task automatic run_conv(input int k_in, input int r, input int p, input int g,
                            input int bias, input bit disturb);
        int     k      = eff_k(k_in);
        int     n      = 1 << k;
        int     t      = len1(r) + len1(p) + 2 * len1(g) + 1;
        int     ones   = 0;
        int     reads  = 0;
        int     rsts   = 0;
        int     prts   = 0;
        int     ord_bad = 0;
        int     len_bad = 0;
        int     hold_bad = 0;
        int     prev_t = 0;
        int     last_t = 0;
        int     run    = 0;
        int     gap    = 0;
        int     c      = 1;
        bit     seen   = 0;
        logic [7:0] old_code = code;

        @(negedge clk);
        trial_log2 = 4'(k_in);
        rst_len = 8'(r); prt_len = 8'(p); gap_len = 8'(g);
        start = 1'b1;
        @(negedge clk);
        if (!disturb) start = 1'b0;
        while (c < 150000) begin
            int ty = rst_pulse ? 1 : (prt_pulse ? 2 : (read_stb ? 3 : 0));
            if (ty != prev_t && prev_t != 0) begin
                int want = (prev_t == 1) ? len1(r) : ((prev_t == 2) ? len1(p) : 1);
                if (run != want) len_bad++;
            end
            if (ty != 0 && ty != prev_t) begin
                if (ty == 1 && !(last_t == 0 || (last_t == 3 && gap == 0))) ord_bad++;
                if (ty == 2 && !(last_t == 1 && gap == len1(g))) ord_bad++;
                if (ty == 3 && !(last_t == 2 && gap == len1(g))) ord_bad++;
                run = 1;
                last_t = ty;
                gap = 0;
            end else if (ty != 0) begin
                run++;
            end else begin
                gap++;
            end
            prev_t = ty;
            if (ty == 1) rsts++;
            if (ty == 2) prts++;
            if (done) begin
                seen = 1;
                break;
            end
            if (code !== old_code) hold_bad++;
            begin
                bit b = (($urandom % 100) < bias);
                sense_bit = b;
                if (ty == 3) begin
                    reads++;
                    ones += int'(b);
                end
            end
            if (disturb) begin
                start = 1'b1;
                rst_len = 8'($urandom % 9); prt_len = 8'($urandom % 9);
                gap_len = 8'($urandom % 9); trial_log2 = 4'($urandom);
            end
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        sense_bit = 1'b0;
        chk(seen, "R8", "done observed", seen, 1);
        chk(c == n * t + 1, "R8", "done latency", c, n * t + 1);
        chk(code == 8'(exp_code(ones, k)), "R7", "code value", code, exp_code(ones, k));
        chk(reads == n, "R5", "trial count", reads, n);
        chk(rsts == n * len1(r) && prts == n * len1(p), "R4", "pulse cycle totals",
            rsts + prts, n * (len1(r) + len1(p)));
        chk(len_bad == 0, "R4", "run lengths", len_bad, 0);
        chk(ord_bad == 0, "R3", "phase order and gaps", ord_bad, 0);
        chk(hold_bad == 0, "R9", "code held while running", hold_bad, 0);
        if (disturb) chk(c == n * t + 1, "R2", "start while busy ignored", c, n * t + 1);
        @(negedge clk);
        chk(!busy && !done, "R8", "idle after done", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5eed_0c0d));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(code == 8'd0, "R1", "code after reset", code, 0);
        chk(!busy && !done && !rst_pulse && !prt_pulse && !read_stb, "R1", "outputs after reset",
            {busy, done, rst_pulse, prt_pulse, read_stb}, 0);

        run_conv(4, 1, 1, 1, 50, 0);      // R5 16 trials, minimum lengths
        run_conv(6, 2, 1, 3, 0, 0);       // R7 all zeros -> 0
        run_conv(6, 1, 2, 1, 100, 0);     // R7 all ones saturates at 255
        run_conv(0, 3, 1, 2, 30, 0);      // R5 clamp low to 16 trials
        run_conv(4, 0, 0, 0, 60, 0);      // R4 zero lengths act as one
        run_conv(7, 2, 1, 2, 40, 1);      // R2 start and settings disturbed mid-run
        run_conv(11, 1, 1, 1, 75, 0);     // R5 default 2048 trials
        run_conv(15, 1, 1, 1, 25, 0);     // R5 clamp high to 4096 trials
        for (int i = 0; i < 6; i++) begin
            run_conv(4 + int'($urandom % 6), int'($urandom % 6), int'($urandom % 6),
                     int'($urandom % 6), int'($urandom % 101), 0);
        end

        held = code;
        repeat (20) begin
            @(negedge clk);
            sense_bit = 1'($urandom);
        end
        chk(code == held, "R9", "code held while idle", code, held);
        chk(!read_stb && !busy, "R6", "no strobe while idle", read_stb, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule